// File: doc/BRIEF.md
# USB Host Pipe Status and Interrupt Flags

This block keeps the status of one host pipe. The pipe transaction engine sends it single-cycle event strobes. The strobes report a handshake, an error, a bank becoming free, a packet arriving or a late OUT packet. The block qualifies each strobe against the pipe's type and direction, then records it in a sticky flag.

Software sees the flags and drives the block through a small register write port:
- it clears flags by writing ones to a clear register;
- it picks which flags may interrupt through an enable mask;
- it uses a control register to release a frozen pipe or to load the data toggle.

The block also makes two decisions for the transaction engine. It decides whether an arriving IN packet goes into the bank, and whether that packet is acknowledged. It also tracks the DATA0/DATA1 toggle of the current bank.

Register map at `wr_addr`:
- 0 is the clear register. A one in bit i clears flag i.
- 1 is the enable mask. It loads the whole mask.
- 2 is the control register. Bit 0 is the unfreeze strobe. Bit 1 is the toggle load strobe. Bits 5:4 hold the toggle value to load.

Flag bit positions:

| Bit | Flag |
|-----|------|
| 0 | IN packet stored |
| 1 | OUT bank free |
| 2 | SETUP bank free |
| 3 | NAK |
| 4 | STALL |
| 5 | pipe error |
| 6 | CRC error |
| 7 | error flow |

Pipe type codes on `pipe_type`:

| Code | Pipe type |
|------|-----------|
| 0 | control |
| 1 | isochronous |
| 2 | bulk |
| 3 | interrupt |

All outputs are registered. An event or write presented before a clock edge is visible on the outputs just after that edge.

Top module: `usbh_pipe_status`

## Requirements
- R1: After reset, `flags` = 0, the enable mask = 0, `irq` = 0, `freeze` = 0, `toggle` = 2'b00, and `pkt_store` = `pkt_ack` = 0.
- R2: Flags 3 (NAK) and 5 (pipe error) set on their strobes for every pipe type and direction. Flag 0 sets when an IN pipe stores a packet. Flag 1 sets on a bank-free strobe only for an OUT pipe (`pipe_in` = 0).
- R3: A STALL strobe on any non-isochronous pipe sets flag 4 and raises `freeze` at the same edge. On an isochronous pipe it changes neither.
- R4: Flag 6 (CRC error) sets only on isochronous pipes.
- R5: Flag 7 (error flow) sets only on isochronous and interrupt pipes. On an OUT pipe it is set by the underflow strobe. On an IN pipe it is set by a packet that arrives while `bank_full` = 1.
- R6: A packet arriving while `bank_full` = 1 is not stored (`pkt_store` = 0). It is acknowledged only on an interrupt pipe. A stored packet is acknowledged on every pipe type except isochronous. `ev_pkt_in` on an OUT pipe has no effect.
- R7: Writing ones to address 0 clears exactly the flags whose bits are one. All other flags keep their value.
- R8: When a set event and a clear bit hit the same flag in one cycle, the flag ends up set.
- R9: `irq` is one exactly when some flag is one and its enable bit (address 1, same bit position) is one.
- R10: `freeze` falls only through a control write with bit 0 = 1. Clearing flag 4 leaves it raised. A STALL in the same cycle as the unfreeze write keeps it raised.
- R11: `toggle` encodes 2'b00 = DATA0 and 2'b01 = DATA1, with 2'b10 and 2'b11 reserved. A `xfer_ok` strobe moves DATA0 to DATA1, and any other value to DATA0.
- R12: A control write with bit 1 = 1 loads `toggle` from bits 5:4, reserved codes included. The load wins over a same-cycle `xfer_ok`. Flag 2 (SETUP free) sets only on control pipes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_type | input | 2 | Pipe type code |
| pipe_in | input | 1 | 1 = IN pipe, 0 = OUT pipe |
| ev_stall | input | 1 | STALL handshake received |
| ev_crc | input | 1 | CRC error on current bank |
| ev_nak | input | 1 | NAK received |
| ev_perr | input | 1 | Pipe error on current bank |
| ev_bank_free | input | 1 | Current OUT bank can be filled |
| ev_setup_free | input | 1 | SETUP bank can be filled |
| ev_pkt_in | input | 1 | IN data packet arrived |
| bank_full | input | 1 | Current bank still occupied |
| ev_underflow | input | 1 | OUT packet due but bank not ready |
| xfer_ok | input | 1 | Transaction completed successfully |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| flags | output | 8 | Sticky status flags |
| irq | output | 1 | OR of enabled flags |
| freeze | output | 1 | Pipe frozen |
| toggle | output | 2 | Data toggle of current bank |
| pkt_store | output | 1 | Arrived packet is written to the bank |
| pkt_ack | output | 1 | Arrived packet is acknowledged |

## Verification
The assertions check several rules on every cycle:
- the interrupt line always matches the enabled flags;
- a non-isochronous STALL always freezes the pipe;
- a CRC flag only ever rises on an isochronous pipe;
- freeze only ever falls after an unfreeze write;
- an overflowing packet is never stored;
- a NAK is never lost to a same-cycle clear.

The bench's sweep over every pipe type, direction and event shows the rest. That covers the full qualification table and the exact ack choice. Directed sequences cover the reserved toggle codes, the load-over-advance priority and the selective clear.

// File: rtl/upst_pkg.sv
package upst_pkg;
  typedef enum logic [1:0] {
    PT_CTRL = 2'd0,
    PT_ISO  = 2'd1,
    PT_BULK = 2'd2,
    PT_INTR = 2'd3
  } pipe_kind_e;

  localparam int NFLAG     = 8;
  localparam int F_RXIN    = 0;
  localparam int F_OUTFREE = 1;
  localparam int F_SETUP   = 2;
  localparam int F_NAK     = 3;
  localparam int F_STALL   = 4;
  localparam int F_PERR    = 5;
  localparam int F_CRC     = 6;
  localparam int F_EFLOW   = 7;

  localparam int TOG_W = 2;
  localparam logic [TOG_W-1:0] TOG_D0 = 2'b00;
  localparam logic [TOG_W-1:0] TOG_D1 = 2'b01;

  localparam int RA_CLR  = 0;
  localparam int RA_ENA  = 1;
  localparam int RA_CTRL = 2;

  localparam int CB_UNFRZ = 0;
  localparam int CB_TLOAD = 1;
  localparam int CB_TVAL  = 4;
endpackage

// File: rtl/upst_event_decode.sv
module upst_event_decode
  import upst_pkg::*;
(
  input  logic [1:0]       pipe_type,
  input  logic             pipe_in,
  input  logic             ev_stall,
  input  logic             ev_crc,
  input  logic             ev_nak,
  input  logic             ev_perr,
  input  logic             ev_bank_free,
  input  logic             ev_setup_free,
  input  logic             ev_pkt_in,
  input  logic             bank_full,
  input  logic             ev_underflow,
  output logic [NFLAG-1:0] set_vec,
  output logic             freeze_set,
  output logic             store,
  output logic             ack
);
  logic is_iso, is_int, is_ctrl, periodic, rx_ok, rx_ovf;

  always_comb begin
    is_iso   = (pipe_type == PT_ISO);
    is_int   = (pipe_type == PT_INTR);
    is_ctrl  = (pipe_type == PT_CTRL);
    periodic = is_iso | is_int;
    rx_ok    = ev_pkt_in & pipe_in & ~bank_full;
    rx_ovf   = ev_pkt_in & pipe_in & bank_full;

    set_vec            = '0;
    set_vec[F_RXIN]    = rx_ok;
    set_vec[F_OUTFREE] = ev_bank_free & ~pipe_in;
    set_vec[F_SETUP]   = ev_setup_free & is_ctrl;
    set_vec[F_NAK]     = ev_nak;
    set_vec[F_STALL]   = ev_stall & ~is_iso;
    set_vec[F_PERR]    = ev_perr;
    set_vec[F_CRC]     = ev_crc & is_iso;
    set_vec[F_EFLOW]   = periodic & (rx_ovf | (ev_underflow & ~pipe_in));

    freeze_set = ev_stall & ~is_iso;
    store      = rx_ok;
    ack        = (rx_ok & ~is_iso) | (rx_ovf & is_int);
  end
endmodule

// File: rtl/upst_flag_bank.sv
module upst_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] en_nxt,
  output logic [N-1:0] flags_q,
  output logic         irq_q
);
  logic [N-1:0] flags_nxt;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // set outranks clear so no event is lost
    assign flags_nxt[i] = set_vec[i] | (flags_q[i] & ~clr_vec[i]);

    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_nxt & en_nxt);
  end
endmodule

// File: rtl/upst_toggle.sv
module upst_toggle #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] tog_q
);
  localparam logic [TW-1:0] D0 = '0;
  localparam logic [TW-1:0] D1 = TW'(1);

  always_ff @(posedge clk) begin
    if (rst)          tog_q <= D0;
    else if (load)    tog_q <= load_val;
    else if (advance) tog_q <= (tog_q == D0) ? D1 : D0;
  end
endmodule

// File: rtl/usbh_pipe_status.sv
module usbh_pipe_status
  import upst_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pipe_type,
  input  logic              pipe_in,
  input  logic              ev_stall,
  input  logic              ev_crc,
  input  logic              ev_nak,
  input  logic              ev_perr,
  input  logic              ev_bank_free,
  input  logic              ev_setup_free,
  input  logic              ev_pkt_in,
  input  logic              bank_full,
  input  logic              ev_underflow,
  input  logic              xfer_ok,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NFLAG-1:0]  flags,
  output logic              irq,
  output logic              freeze,
  output logic [TOG_W-1:0]  toggle,
  output logic              pkt_store,
  output logic              pkt_ack
);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(RA_CLR);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(RA_ENA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(RA_CTRL);

  logic [NFLAG-1:0] set_vec, clr_vec, en_q, en_nxt;
  logic             freeze_set, store_c, ack_c;
  logic             wr_clr, wr_ena, wr_ctrl, unfreeze, tload;

  assign wr_clr   = wr_en & (wr_addr == A_CLR);
  assign wr_ena   = wr_en & (wr_addr == A_ENA);
  assign wr_ctrl  = wr_en & (wr_addr == A_CTRL);
  assign unfreeze = wr_ctrl & wr_data[CB_UNFRZ];
  assign tload    = wr_ctrl & wr_data[CB_TLOAD];
  assign clr_vec  = wr_clr ? wr_data[NFLAG-1:0] : '0;
  assign en_nxt   = wr_ena ? wr_data[NFLAG-1:0] : en_q;

  upst_event_decode u_dec (
    .pipe_type     (pipe_type),
    .pipe_in       (pipe_in),
    .ev_stall      (ev_stall),
    .ev_crc        (ev_crc),
    .ev_nak        (ev_nak),
    .ev_perr       (ev_perr),
    .ev_bank_free  (ev_bank_free),
    .ev_setup_free (ev_setup_free),
    .ev_pkt_in     (ev_pkt_in),
    .bank_full     (bank_full),
    .ev_underflow  (ev_underflow),
    .set_vec       (set_vec),
    .freeze_set    (freeze_set),
    .store         (store_c),
    .ack           (ack_c)
  );

  upst_flag_bank #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .en_nxt  (en_nxt),
    .flags_q (flags),
    .irq_q   (irq)
  );

  upst_toggle #(.TW(TOG_W)) u_tog (
    .clk      (clk),
    .rst      (rst),
    .advance  (xfer_ok),
    .load     (tload),
    .load_val (wr_data[CB_TVAL +: TOG_W]),
    .tog_q    (toggle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      freeze    <= 1'b0;
      pkt_store <= 1'b0;
      pkt_ack   <= 1'b0;
    end else begin
      en_q      <= en_nxt;
      pkt_store <= store_c;
      pkt_ack   <= ack_c;
      if (freeze_set)    freeze <= 1'b1;
      else if (unfreeze) freeze <= 1'b0;
    end
  end
endmodule

// File: rtl/usbh_pipe_status_chk.sv
module usbh_pipe_status_chk
  import upst_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        pipe_type,
  input logic              ev_stall,
  input logic              ev_nak,
  input logic              ev_pkt_in,
  input logic              bank_full,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  en_q,
  input logic              irq,
  input logic              freeze,
  input logic              pkt_store,
  input logic              pkt_ack
);
  AST_IRQ_MATCHES_ENABLED: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & en_q)); // R9
  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (ev_stall && pipe_type != PT_ISO) |=> (freeze && flags[F_STALL])); // R3
  AST_CRC_ONLY_ISO: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[F_CRC]) |-> ($past(pipe_type) == PT_ISO)); // R4
  AST_FREEZE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(freeze) |-> $past(wr_en && wr_addr == ADDR_W'(RA_CTRL) && wr_data[CB_UNFRZ])); // R10
  AST_OVF_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
    (ev_pkt_in && bank_full) |=> !pkt_store); // R6
  AST_ISO_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (pipe_type == PT_ISO) |=> !pkt_ack); // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ev_nak |=> flags[F_NAK]); // R8
endmodule

bind usbh_pipe_status usbh_pipe_status_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pipe_type (pipe_type),
  .ev_stall  (ev_stall),
  .ev_nak    (ev_nak),
  .ev_pkt_in (ev_pkt_in),
  .bank_full (bank_full),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .flags     (flags),
  .en_q      (en_q),
  .irq       (irq),
  .freeze    (freeze),
  .pkt_store (pkt_store),
  .pkt_ack   (pkt_ack)
);

// File: tb/usbh_pipe_status_bench.sv
module usbh_pipe_status_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pipe_type = 2'd0;
  logic       pipe_in = 1'b0;
  logic ev_stall = 0, ev_crc = 0, ev_nak = 0, ev_perr = 0, ev_bank_free = 0;
  logic ev_setup_free = 0, ev_pkt_in = 0, bank_full = 0, ev_underflow = 0, xfer_ok = 0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] flags;
  logic       irq, freeze, pkt_store, pkt_ack;
  logic [1:0] toggle;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  usbh_pipe_status u_usbh_pipe_status (
    .clk(clk), .rst(rst), .pipe_type(pipe_type), .pipe_in(pipe_in),
    .ev_stall(ev_stall), .ev_crc(ev_crc), .ev_nak(ev_nak), .ev_perr(ev_perr),
    .ev_bank_free(ev_bank_free), .ev_setup_free(ev_setup_free),
    .ev_pkt_in(ev_pkt_in), .bank_full(bank_full), .ev_underflow(ev_underflow),
    .xfer_ok(xfer_ok), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flags(flags), .irq(irq), .freeze(freeze), .toggle(toggle),
    .pkt_store(pkt_store), .pkt_ack(pkt_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    {ev_stall, ev_crc, ev_nak, ev_perr, ev_bank_free, ev_setup_free} = '0;
    {ev_pkt_in, bank_full, ev_underflow, xfer_ok, wr_en} = '0;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R1 reset state
    check("R1 flags", flags, 0);
    check("R1 irq", irq, 0);
    check("R1 freeze", freeze, 0);
    check("R1 toggle", toggle, 0);
    check("R1 store/ack", {pkt_store, pkt_ack}, 0);

    // R2 R3 R4 R5 R6 R12: sweep type x direction x event
    for (int t = 0; t < 4; t++) begin
      for (int d = 0; d < 2; d++) begin
        for (int e = 0; e < 9; e++) begin
          logic [7:0] ef;
          logic ez, es, ea, per;
          pipe_type = t[1:0]; pipe_in = d[0];
          per = (t == 1) || (t == 3);
          ef = 0; ez = 0; es = 0; ea = 0;
          case (e)
            0: begin ev_stall = 1; if (t != 1) begin ef[4] = 1; ez = 1; end end
            1: begin ev_crc = 1; if (t == 1) ef[6] = 1; end
            2: begin ev_nak = 1; ef[3] = 1; end
            3: begin ev_perr = 1; ef[5] = 1; end
            4: begin ev_bank_free = 1; if (d == 0) ef[1] = 1; end
            5: begin ev_setup_free = 1; if (t == 0) ef[2] = 1; end
            6: begin ev_pkt_in = 1;
                 if (d == 1) begin ef[0] = 1; es = 1; ea = (t != 1); end end
            7: begin ev_pkt_in = 1; bank_full = 1;
                 if (d == 1) begin ea = (t == 3); if (per) ef[7] = 1; end end
            default: begin ev_underflow = 1; if (d == 0 && per) ef[7] = 1; end
          endcase
          tick();
          check($sformatf("R2-R5/R12 flags t%0d d%0d e%0d", t, d, e), flags, ef);
          check($sformatf("R3 freeze t%0d d%0d e%0d", t, d, e), freeze, ez);
          check($sformatf("R6 store t%0d d%0d e%0d", t, d, e), pkt_store, es);
          check($sformatf("R6 ack t%0d d%0d e%0d", t, d, e), pkt_ack, ea);
          reg_wr(2'd0, 8'hFF); tick();
          reg_wr(2'd2, 8'h01); tick();
          check("R7 all cleared", flags, 0);
          check("R10 unfreeze", freeze, 0);
        end
      end
    end

    // R7 selective clear
    pipe_type = 2'd2; pipe_in = 1'b0;
    ev_nak = 1; ev_perr = 1; tick();
    reg_wr(2'd0, 8'h08); tick();
    check("R7 selective clear", flags, 8'h20);
    // R8 set beats clear
    ev_nak = 1; reg_wr(2'd0, 8'h08); tick();
    check("R8 set wins", flags, 8'h28);
    // R9 enable and irq
    reg_wr(2'd1, 8'h01); tick();
    check("R9 irq masked", irq, 0);
    reg_wr(2'd1, 8'h08); tick();
    check("R9 irq enabled", irq, 1);
    reg_wr(2'd0, 8'h08); tick();
    check("R9 irq after clear", irq, 0);
    reg_wr(2'd0, 8'hFF); tick();

    // R10 freeze release rules
    ev_stall = 1; tick();
    check("R10 frozen", freeze, 1);
    reg_wr(2'd0, 8'h10); tick();
    check("R10 flag cleared", flags[4], 0);
    check("R10 still frozen", freeze, 1);
    ev_stall = 1; reg_wr(2'd2, 8'h01); tick();
    check("R10 stall beats unfreeze", freeze, 1);
    reg_wr(2'd2, 8'h01); tick();
    check("R10 released", freeze, 0);

    // R11 R12 toggle
    xfer_ok = 1; tick();
    check("R11 D0->D1", toggle, 2'b01);
    xfer_ok = 1; tick();
    check("R11 D1->D0", toggle, 2'b00);
    reg_wr(2'd2, 8'h32); tick();
    check("R12 load reserved", toggle, 2'b11);
    xfer_ok = 1; tick();
    check("R11 reserved->D0", toggle, 2'b00);
    xfer_ok = 1; reg_wr(2'd2, 8'h22); tick();
    check("R12 load beats advance", toggle, 2'b10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule